// File: doc/BRIEF.md
# Clipped Histogram Excess Redistribution and Mapping Table Builder

This block finishes the per-tile work of a contrast-limited adaptive equalizer. It starts from a histogram that has already been cut at the clip limit and from the number of pixels the cut removed. It returns those pixels to the histogram over several passes and never lets any bin rise above the clip limit. When the pool of removed pixels is empty, or when no bin can take more, it turns the histogram into a cumulative distribution. It scales that distribution to the output intensity range and writes the result into a mapping table, one entry per bin.

Both the histogram and the mapping table live in RAMs outside the block. The block reads the histogram through a read port with one cycle of latency. It writes updated bin counts back through a separate write port, and it fills the mapping table through a write-only port. A caller loads the histogram and pulses `start` with the clip limit and the excess count. When the table is complete, the block pulses `done`.

Each redistribution pass streams every bin once. In a pass, the pool is divided by the number of bins still below the clip limit, and each of those bins receives the whole-number share. A bin that would go above the limit is filled only to the limit, and the surplus stays in the pool for the next pass. When the share falls to zero, the remaining pixels are handed out one at a time.

Top module: `clahe_redist`

## Requirements
- R1: A `start` pulse is accepted only while the block is idle. It latches `clip_limit` and `excess_in`, and a `start` during a run has no effect on that run's results or on the number of `done` pulses.
- R2: No histogram write ever carries a value above the clip limit latched at the accepted `start`.
- R3: In each spreading pass, the share is the pool divided by the number of open bins (bins below the clip limit), with the remainder dropped. Each open bin gains the smaller of the share and its room to the limit, and the amount placed leaves the pool. Passes repeat while both the pool and the open-bin count are non-zero.
- R4: When the share is zero, the remaining pool is placed one pixel per open bin, walking bins in ascending index order until the pool is empty.
- R5: When no bin is below the clip limit, redistribution stops and any remaining pool is discarded; the histogram is left unchanged.
- R6: With a zero excess, the histogram RAM receives no writes.
- R7: Entry n of the mapping table equals min(2^OUT_W-1, floor((S_n·(2^OUT_W-1) + floor(TILE_PIX/2)) / TILE_PIX)), where S_n is the sum of final bin counts 0..n.
- R8: The mapping table is written exactly once per bin, at addresses 0, 1, …, NBINS-1 in consecutive cycles.
- R9: `done` is high for exactly one cycle, the cycle right after the last mapping-table write, once per accepted `start`.
- R10: During reset, and whenever no run is in progress, no read or write strobe is asserted and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the loaded histogram |
| clip_limit | input | CNT_W | Per-bin ceiling, latched at start |
| excess_in | input | EXC_W | Pixels removed by clipping, latched at start |
| hist_rd_en | output | 1 | Histogram read strobe |
| hist_rd_addr | output | AW | Histogram read address |
| hist_rd_data | input | CNT_W | Histogram read data, one cycle after the strobe |
| hist_wr_en | output | 1 | Histogram write strobe |
| hist_wr_addr | output | AW | Histogram write address |
| hist_wr_data | output | CNT_W | Updated bin count |
| map_wr_en | output | 1 | Mapping-table write strobe |
| map_wr_addr | output | AW | Mapping-table address (input intensity) |
| map_wr_data | output | OUT_W | Output intensity for that address |
| done | output | 1 | One-cycle pulse after the last table write |

## Verification
A wrong pool or open-bin count inside the block first shows up in the bin values written back to the histogram RAM. In the passes that follow it changes which bins saturate and how many passes run. Every mapping entry at and after the first wrong bin then shifts, because the cumulative sum carries the error forward. The final histogram is therefore compared bin by bin, and so is the whole table, which places an error to within a pass and a bin. A fault in sequencing shows up within a cycle as an out-of-order table address, a stray strobe while idle, or a `done` that does not directly follow the last write.

// File: rtl/clahe_redist_pkg.sv
package clahe_redist_pkg;

    // Top-level control phase
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCAN,
        PH_CHECK,
        PH_DIVIDE,
        PH_REDIST,
        PH_CDF
    } phase_t;

    // Kind of work done on each bin during one streaming sweep
    typedef enum logic [1:0] {
        SW_SCAN,     // count bins still below the limit
        SW_SPREAD,   // add the per-pass share, capped at the limit
        SW_TRICKLE,  // add one pixel per open bin while the pool lasts
        SW_CDF       // accumulate and emit mapping entries
    } sweep_t;

endpackage

// File: rtl/clahe_addr_sweep.sv
module clahe_addr_sweep #(
    parameter int NBINS = 256,
    localparam int AW = $clog2(NBINS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          stg_valid,
    output logic [AW-1:0] stg_addr,
    output logic          stg_last
);
    localparam logic [AW-1:0] LAST = AW'(NBINS - 1);

    logic          active;
    logic [AW-1:0] cnt;

    assign rd_en   = active;
    assign rd_addr = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cnt       <= '0;
            stg_valid <= 1'b0;
            stg_addr  <= '0;
            stg_last  <= 1'b0;
        end else begin
            // read data returns one cycle after the strobe
            stg_valid <= active;
            stg_addr  <= cnt;
            stg_last  <= active && (cnt == LAST);
            if (kick) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    active <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/clahe_seq_div.sv
module clahe_seq_div #(
    parameter int NW = 16,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quot
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0] q;
    logic [DW:0]   rem;
    logic [CW-1:0] left;
    logic          run;
    logic [DW:0]   shifted;
    logic [DW+1:0] diff;

    always_comb begin
        shifted = {rem[DW-1:0], q[NW-1]};
        diff    = {1'b0, shifted} - {2'b00, den};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            rem  <= '0;
            left <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                q    <= num;
                rem  <= '0;
                left <= CW'(NW);
                run  <= 1'b1;
            end else if (run) begin
                if (!diff[DW+1]) begin
                    rem <= diff[DW:0];
                    q   <= {q[NW-2:0], 1'b1};
                end else begin
                    rem <= shifted;
                    q   <= {q[NW-2:0], 1'b0};
                end
                left <= left - 1'b1;
                if (left == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q;
endmodule

// File: rtl/clahe_bin_update.sv
module clahe_bin_update
    import clahe_redist_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int EXC_W = 16   // must not be narrower than CNT_W
) (
    input  sweep_t             mode,
    input  logic [CNT_W-1:0]   count,
    input  logic [CNT_W-1:0]   clip,
    input  logic [EXC_W-1:0]   share,
    input  logic [EXC_W-1:0]   pool,
    output logic [CNT_W-1:0]   new_count,
    output logic [EXC_W-1:0]   placed,
    output logic               open_before,
    output logic               open_after
);
    logic [CNT_W-1:0] room;
    logic [EXC_W-1:0] room_x;
    logic [EXC_W-1:0] add;

    always_comb begin
        open_before = (count < clip);
        room        = open_before ? (clip - count) : '0;
        room_x      = EXC_W'(room);
        add         = '0;
        unique case (mode)
            SW_SPREAD: begin
                if (open_before) begin
                    add = (share > room_x) ? room_x : share;
                end
            end
            SW_TRICKLE: begin
                if (open_before && (pool != '0)) begin
                    add = EXC_W'(1);
                end
            end
            default: add = '0;
        endcase
        placed     = add;
        new_count  = count + CNT_W'(add);
        open_after = (new_count < clip);
    end
endmodule

// File: rtl/clahe_cdf_map.sv
module clahe_cdf_map #(
    parameter int NBINS    = 256,
    parameter int CNT_W    = 12,
    parameter int OUT_W    = 8,
    parameter int TILE_PIX = 4096,
    localparam int AW = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [AW-1:0]    in_addr,
    input  logic [CNT_W-1:0] in_count,
    output logic             map_wr_en,
    output logic [AW-1:0]    map_wr_addr,
    output logic [OUT_W-1:0] map_wr_data,
    output logic             done
);
    localparam int SUM_W  = CNT_W + AW;
    localparam int PROD_W = SUM_W + OUT_W + 2;
    localparam int MAXV   = (1 << OUT_W) - 1;
    localparam logic [PROD_W-1:0] MAXV_P = PROD_W'(MAXV);
    localparam logic [PROD_W-1:0] TILE_P = PROD_W'(TILE_PIX);
    localparam logic [PROD_W-1:0] HALF_P = PROD_W'(TILE_PIX / 2);

    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  next_sum;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] level_wide;
    logic [OUT_W-1:0]  level;
    logic              last_q;

    always_comb begin
        next_sum   = sum + SUM_W'(in_count);
        prod       = PROD_W'(next_sum) * MAXV_P + HALF_P;
        level_wide = prod / TILE_P;
        level      = (level_wide > MAXV_P) ? OUT_W'(MAXV) : level_wide[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum         <= '0;
            map_wr_en   <= 1'b0;
            map_wr_addr <= '0;
            map_wr_data <= '0;
            last_q      <= 1'b0;
            done        <= 1'b0;
        end else begin
            map_wr_en   <= in_valid;
            map_wr_addr <= in_addr;
            map_wr_data <= level;
            last_q      <= in_valid && in_last;
            done        <= last_q;
            if (clear) begin
                sum <= '0;
            end else if (in_valid) begin
                sum <= next_sum;
            end
        end
    end
endmodule

// File: rtl/clahe_redist.sv
module clahe_redist
    import clahe_redist_pkg::*;
#(
    parameter int NBINS    = 256,
    parameter int CNT_W    = 12,
    parameter int EXC_W    = 16,
    parameter int OUT_W    = 8,
    parameter int TILE_PIX = 4096,
    localparam int AW = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] clip_limit,
    input  logic [EXC_W-1:0] excess_in,
    output logic             hist_rd_en,
    output logic [AW-1:0]    hist_rd_addr,
    input  logic [CNT_W-1:0] hist_rd_data,
    output logic             hist_wr_en,
    output logic [AW-1:0]    hist_wr_addr,
    output logic [CNT_W-1:0] hist_wr_data,
    output logic             map_wr_en,
    output logic [AW-1:0]    map_wr_addr,
    output logic [OUT_W-1:0] map_wr_data,
    output logic             done
);
    localparam int UW = $clog2(NBINS + 1);

    phase_t           phase;
    sweep_t           pass_q;
    logic [CNT_W-1:0] clip_q;
    logic [EXC_W-1:0] pool;
    logic [EXC_W-1:0] share_q;
    logic [UW-1:0]    open_cnt;
    logic [UW-1:0]    open_acc;
    logic [UW-1:0]    open_acc_next;

    logic             kick;
    logic             stg_valid;
    logic [AW-1:0]    stg_addr;
    logic             stg_last;

    logic [CNT_W-1:0] new_count;
    logic [EXC_W-1:0] placed;
    logic             open_before;
    logic             open_after;
    logic             inc;
    logic             redist_pass;

    logic             finish_redist;
    logic             div_go;
    logic             div_done;
    logic [EXC_W-1:0] div_quot;
    logic             cdf_valid;
    logic             cdf_done;

    clahe_addr_sweep #(.NBINS(NBINS)) u_sweep (
        .clk      (clk),
        .rst      (rst),
        .kick     (kick),
        .rd_en    (hist_rd_en),
        .rd_addr  (hist_rd_addr),
        .stg_valid(stg_valid),
        .stg_addr (stg_addr),
        .stg_last (stg_last)
    );

    clahe_bin_update #(.CNT_W(CNT_W), .EXC_W(EXC_W)) u_update (
        .mode       (pass_q),
        .count      (hist_rd_data),
        .clip       (clip_q),
        .share      (share_q),
        .pool       (pool),
        .new_count  (new_count),
        .placed     (placed),
        .open_before(open_before),
        .open_after (open_after)
    );

    clahe_seq_div #(.NW(EXC_W), .DW(UW)) u_div (
        .clk (clk),
        .rst (rst),
        .go  (div_go),
        .num (pool),
        .den (open_cnt),
        .done(div_done),
        .quot(div_quot)
    );

    clahe_cdf_map #(
        .NBINS(NBINS), .CNT_W(CNT_W), .OUT_W(OUT_W), .TILE_PIX(TILE_PIX)
    ) u_cdf (
        .clk        (clk),
        .rst        (rst),
        .clear      (finish_redist),
        .in_valid   (cdf_valid),
        .in_last    (stg_last),
        .in_addr    (stg_addr),
        .in_count   (hist_rd_data),
        .map_wr_en  (map_wr_en),
        .map_wr_addr(map_wr_addr),
        .map_wr_data(map_wr_data),
        .done       (cdf_done)
    );

    assign done = cdf_done;

    always_comb begin
        redist_pass   = (pass_q == SW_SPREAD) || (pass_q == SW_TRICKLE);
        cdf_valid     = stg_valid && (pass_q == SW_CDF);
        finish_redist = (phase == PH_CHECK) && ((pool == '0) || (open_cnt == '0));
        div_go        = (phase == PH_CHECK) && !finish_redist;
        kick          = ((phase == PH_IDLE) && start)
                     || finish_redist
                     || ((phase == PH_DIVIDE) && div_done);
        unique case (pass_q)
            SW_SCAN:               inc = open_before;
            SW_SPREAD, SW_TRICKLE: inc = open_after;
            default:               inc = 1'b0;
        endcase
        open_acc_next = open_acc + UW'(inc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            pass_q       <= SW_SCAN;
            clip_q       <= '0;
            pool         <= '0;
            share_q      <= '0;
            open_cnt     <= '0;
            open_acc     <= '0;
            hist_wr_en   <= 1'b0;
            hist_wr_addr <= '0;
            hist_wr_data <= '0;
        end else begin
            hist_wr_en   <= stg_valid && redist_pass && (placed != '0);
            hist_wr_addr <= stg_addr;
            hist_wr_data <= new_count;

            if (stg_valid && redist_pass) begin
                pool <= pool - placed;
            end
            if (stg_valid && (pass_q != SW_CDF)) begin
                open_acc <= stg_last ? '0 : open_acc_next;
            end

            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        clip_q <= clip_limit;
                        pool   <= excess_in;
                        pass_q <= SW_SCAN;
                        phase  <= PH_SCAN;
                    end
                end
                PH_SCAN, PH_REDIST: begin
                    if (stg_valid && stg_last) begin
                        open_cnt <= open_acc_next;
                        phase    <= PH_CHECK;
                    end
                end
                PH_CHECK: begin
                    if (finish_redist) begin
                        pass_q <= SW_CDF;
                        phase  <= PH_CDF;
                    end else begin
                        phase <= PH_DIVIDE;
                    end
                end
                PH_DIVIDE: begin
                    if (div_done) begin
                        share_q <= div_quot;
                        pass_q  <= (div_quot == '0) ? SW_TRICKLE : SW_SPREAD;
                        phase   <= PH_REDIST;
                    end
                end
                PH_CDF: begin
                    if (cdf_done) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clahe_redist_chk.sv
module clahe_redist_chk #(
    parameter int NBINS = 256,
    parameter int CNT_W = 12,
    localparam int AW = $clog2(NBINS)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] clip_limit,
    input logic             hist_rd_en,
    input logic             hist_wr_en,
    input logic [CNT_W-1:0] hist_wr_data,
    input logic             map_wr_en,
    input logic [AW-1:0]    map_wr_addr,
    input logic             done
);
    logic             busy_q;
    logic [CNT_W-1:0] clip_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            clip_seen <= '0;
        end else if (start && !busy_q) begin
            busy_q    <= 1'b1;
            clip_seen <= clip_limit;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    assert_clip_cap_R2: assert property (@(posedge clk) disable iff (rst)
        hist_wr_en |-> (hist_wr_data <= clip_seen));

    assert_map_first_R8: assert property (@(posedge clk) disable iff (rst)
        (map_wr_en && !$past(map_wr_en)) |-> (map_wr_addr == '0));

    assert_map_step_R8: assert property (@(posedge clk) disable iff (rst)
        (map_wr_en && $past(map_wr_en)) |-> (map_wr_addr == $past(map_wr_addr) + 1'b1));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(map_wr_en) && ($past(map_wr_addr) == AW'(NBINS - 1)) && !map_wr_en));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (!hist_rd_en && !hist_wr_en && !map_wr_en && !done));
endmodule

bind clahe_redist clahe_redist_chk #(.NBINS(NBINS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .clip_limit  (clip_limit),
    .hist_rd_en  (hist_rd_en),
    .hist_wr_en  (hist_wr_en),
    .hist_wr_data(hist_wr_data),
    .map_wr_en   (map_wr_en),
    .map_wr_addr (map_wr_addr),
    .done        (done)
);

// File: tb/clahe_redist_test.sv
module clahe_redist_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 16;
    localparam int CW   = 8;
    localparam int EW   = 12;
    localparam int OW   = 8;
    localparam int TILE = 512;
    localparam int AW   = $clog2(NB);
    localparam int MAXV = (1 << OW) - 1;
    localparam int WD_LIMIT = 190000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] clip = '0;
    logic [EW-1:0] excess = '0;
    logic          hist_rd_en;
    logic [AW-1:0] hist_rd_addr;
    logic [CW-1:0] hist_rd_data = '0;
    logic          hist_wr_en;
    logic [AW-1:0] hist_wr_addr;
    logic [CW-1:0] hist_wr_data;
    logic          map_wr_en;
    logic [AW-1:0] map_wr_addr;
    logic [OW-1:0] map_wr_data;
    logic          done;

    clahe_redist #(
        .NBINS(NB), .CNT_W(CW), .EXC_W(EW), .OUT_W(OW), .TILE_PIX(TILE)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .clip_limit(clip), .excess_in(excess),
        .hist_rd_en(hist_rd_en), .hist_rd_addr(hist_rd_addr), .hist_rd_data(hist_rd_data),
        .hist_wr_en(hist_wr_en), .hist_wr_addr(hist_wr_addr), .hist_wr_data(hist_wr_data),
        .map_wr_en(map_wr_en), .map_wr_addr(map_wr_addr), .map_wr_data(map_wr_data),
        .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // memory models and event recorders
    logic [CW-1:0] hmem [NB];
    logic [OW-1:0] mmem [NB];
    int cyc = 0;
    int hist_writes, map_writes, done_cnt, last_map_cyc, done_cyc, order_err, next_map;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (hist_rd_en) hist_rd_data <= hmem[hist_rd_addr];
        if (hist_wr_en) begin
            hmem[hist_wr_addr] <= hist_wr_data;
            hist_writes <= hist_writes + 1;
        end
        if (map_wr_en) begin
            mmem[map_wr_addr] <= map_wr_data;
            if (int'(map_wr_addr) != next_map) order_err <= order_err + 1;
            next_map     <= next_map + 1;
            map_writes   <= map_writes + 1;
            last_map_cyc <= cyc;
        end
        if (done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    int exp_h [NB];
    int exp_m [NB];
    int unsigned seed = 32'h1F3A_5C71;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rnd(output int unsigned v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v = seed;
    endtask

    // expected results straight from the requirements
    task automatic model(input int c_clip, input int c_exc);
        int h [NB];
        int e, u, s, sum, m, add;
        for (int i = 0; i < NB; i++) h[i] = int'(hmem[i]);
        e = c_exc;
        u = 0;
        for (int i = 0; i < NB; i++) if (h[i] < c_clip) u++;
        while (e > 0 && u > 0) begin
            s = e / u;
            if (s == 0) begin
                for (int i = 0; i < NB; i++)
                    if (h[i] < c_clip && e > 0) begin h[i]++; e--; end
            end else begin
                for (int i = 0; i < NB; i++)
                    if (h[i] < c_clip) begin
                        add = (s < c_clip - h[i]) ? s : c_clip - h[i];
                        h[i] += add;
                        e -= add;
                    end
            end
            u = 0;
            for (int i = 0; i < NB; i++) if (h[i] < c_clip) u++;
        end
        sum = 0;
        for (int i = 0; i < NB; i++) begin
            exp_h[i] = h[i];
            sum += h[i];
            m = (sum * MAXV + TILE / 2) / TILE;
            exp_m[i] = (m > MAXV) ? MAXV : m;
        end
    endtask

    task automatic run_case(input int c_clip, input int c_exc, input bit restart_mid,
                            input bit expect_no_writes, input string name);
        int guard;
        int maxh;
        @(negedge clk);
        hist_writes = 0; map_writes = 0; done_cnt = 0; order_err = 0; next_map = 0;
        last_map_cyc = -10; done_cyc = -20;
        for (int i = 0; i < NB; i++) mmem[i] = '0;
        model(c_clip, c_exc);
        start = 1'b1; clip = CW'(c_clip); excess = EW'(c_exc);
        @(negedge clk);
        start = 1'b0;
        if (restart_mid) begin
            repeat (6) @(negedge clk);
            start = 1'b1; clip = CW'(c_clip / 2); excess = EW'(c_exc + 37);
            @(negedge clk);
            start = 1'b0; clip = CW'(c_clip); excess = EW'(c_exc);
        end
        guard = 0;
        while (done_cnt == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        // R1 and R9: one done per accepted start, directly after the last table write
        check(done_cnt == 1, {"R1/R9 done count ", name}, done_cnt, 1);
        check(done_cyc == last_map_cyc + 1, {"R9 done timing ", name}, done_cyc, last_map_cyc + 1);
        // R8: every address once, ascending
        check(map_writes == NB && order_err == 0, {"R8 table order ", name}, map_writes, NB);
        maxh = 0;
        for (int i = 0; i < NB; i++) begin
            if (int'(hmem[i]) > maxh) maxh = int'(hmem[i]);
            // R3/R4/R5: redistributed bin values
            check(int'(hmem[i]) == exp_h[i], {"R3 bin ", name}, int'(hmem[i]), exp_h[i]);
            // R7: scaled cumulative sum
            check(int'(mmem[i]) == exp_m[i], {"R7 map ", name}, int'(mmem[i]), exp_m[i]);
        end
        check(maxh <= c_clip, {"R2 cap ", name}, maxh, c_clip);
        if (expect_no_writes)
            check(hist_writes == 0, {"R5/R6 no writes ", name}, hist_writes, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            if (cyc > WD_LIMIT) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, WD_LIMIT);
                finish_run();
            end
        end
    end

    initial begin : stimulus
        int unsigned v;
        int c_clip, c_exc;
        for (int i = 0; i < NB; i++) hmem[i] = '0;
        repeat (3) @(negedge clk);
        // R10: quiet in reset
        check(!done && !map_wr_en && !hist_wr_en && !hist_rd_en, "R10 in reset",
              int'({done, map_wr_en, hist_wr_en, hist_rd_en}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && !map_wr_en && !hist_wr_en && !hist_rd_en, "R10 idle after reset",
              int'({done, map_wr_en, hist_wr_en, hist_rd_en}), 0);

        // exact single-pass fill
        for (int i = 0; i < NB; i++) hmem[i] = 8'd10;
        run_case(20, 160, 1'b0, 1'b0, "R3 exact");

        // multi-pass with overflow, then trickle
        for (int i = 0; i < NB; i++) hmem[i] = (i < 8) ? 8'd28 : 8'd5;
        run_case(30, 100, 1'b0, 1'b0, "R3 multipass");

        // trickle only, skipping a saturated bin
        for (int i = 0; i < NB; i++) hmem[i] = '0;
        hmem[1] = 8'd50;
        run_case(50, 5, 1'b0, 1'b0, "R4 trickle");

        // every bin already at the limit: excess discarded
        for (int i = 0; i < NB; i++) hmem[i] = 8'd10;
        run_case(10, 50, 1'b0, 1'b1, "R5 full");

        // excess larger than all room: fills and discards rest
        for (int i = 0; i < NB; i++) hmem[i] = (i % 3 == 0) ? 8'd40 : 8'd3;
        run_case(40, 2000, 1'b0, 1'b0, "R5 overflow");

        // zero excess leaves histogram alone
        for (int i = 0; i < NB; i++) hmem[i] = CW'(i);
        run_case(15, 0, 1'b0, 1'b1, "R6 zero");

        // table saturates at the top intensity
        for (int i = 0; i < NB; i++) hmem[i] = 8'd60;
        run_case(255, 0, 1'b0, 1'b1, "R7 saturate");

        // a start during a run is ignored
        for (int i = 0; i < NB; i++) hmem[i] = CW'(2 * i);
        run_case(32, 300, 1'b1, 1'b0, "R1 restart");

        // sweep of generated tiles
        for (int k = 0; k < 110; k++) begin
            rnd(v);
            c_clip = (k % 4 == 3) ? 1 + int'(v % 200) : 1 + int'(v % 64);
            rnd(v);
            c_exc = int'(v % 1500);
            for (int i = 0; i < NB; i++) begin
                rnd(v);
                hmem[i] = CW'(v % (c_clip + 1));
            end
            run_case(c_clip, c_exc, 1'b0, 1'b0, "sweep");
        end
        finish_run();
    end
endmodule